// File: doc/BRIEF.md
# Luma and Colour-Difference Input Formatter

This block is the front end of a digital video encoder. On every rising pixel clock it takes one 8-bit luma byte and one 8-bit colour-difference byte. The colour-difference stream is time-multiplexed, and the block sorts it into separate Cb and Cr components. It clamps every sample to its legal video range and turns the chroma into offset-binary form. Each pixel leaves the block as a Y, Cb, Cr triple with a valid flag, one clock after its inputs were sampled.

A line-start strobe marks the first active pixel after the back porch. That pixel occupies chroma slot 0. The block supports two chroma layouts. In 4:2:2 the slots alternate between the two components. In 4:1:1 the stream repeats every four slots: the first two slots carry data and the last two are discarded. Which component comes first depends on an order pin, and a software inversion bit can flip the meaning of that pin.

Some inputs are faulty and hold the chroma byte at 0x00 or 0xFF. When the byte shows one of these codes on two clocks in a row, the block recognises the stuck input and drives both chroma outputs to neutral grey. A manual kill control forces the same monochrome output.

Top module: `chroma_luma_formatter`

## Requirements
- R1: `out_y` equals `luma_in` clamped to 16..235 (below 16 gives 16, above 235 gives 235), one clock after sampling.
- R2: With `chroma_twos` = 0, the chroma byte is read as unsigned and clamped to 16..240 before it is stored in Cb or Cr.
- R3: With `chroma_twos` = 1, the chroma byte is read as signed, clamped to -112..+112, then output in offset-binary form (value + 128). For example, 0x80 gives 16, 0x70 gives 240 and 0x00 gives 128.
- R4: The slot sampled together with `line_start` = 1 is slot 0. Slot 0 holds Cb when `order_pin` XOR `order_invert` = 1, and Cr otherwise.
- R5: In 4:2:2 (`fmt_411` = 0), even slots carry the first component and odd slots carry the other. Each output component holds its last stored value until its next slot arrives.
- R6: In 4:1:1 (`fmt_411` = 1), slot 0 carries the first component and slot 1 the second. Slots 2 and 3 change neither output, and slot counting wraps after slot 3.
- R7: When the raw chroma byte is 0x00 or 0xFF on the current clock and was also 0x00 or 0xFF on the previous clock, both `out_cb` and `out_cr` become 128. A single such byte has no effect. Kill ends on the first clock that carries any other byte, and from then on each component is refilled only at its own slot.
- R8: `kill_force` = 1 sets both `out_cb` and `out_cr` to 128 on the next clock, whatever the chroma data is.
- R9: `out_valid` is 0 after reset. It becomes 1 one clock after the first `line_start` and stays 1 until the next reset.
- R10: While `rst` is high, the outputs are `out_y` = 16, `out_cb` = `out_cr` = 128 and `out_valid` = 0. The slot counter and the stuck-byte history are also cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| luma_in | input | 8 | Luma sample |
| chroma_in | input | 8 | Multiplexed colour-difference sample |
| order_pin | input | 1 | Chroma order select from the board |
| order_invert | input | 1 | Inverts the meaning of `order_pin` |
| fmt_411 | input | 1 | 1 = 4:1:1 layout, 0 = 4:2:2 layout |
| chroma_twos | input | 1 | 1 = chroma input is two's complement |
| line_start | input | 1 | Marks the first active pixel of a line |
| kill_force | input | 1 | Manual colour kill |
| out_y | output | 8 | Clamped luma |
| out_cb | output | 8 | Cb, offset binary |
| out_cr | output | 8 | Cr, offset binary |
| out_valid | output | 1 | Output pixel is valid |

## Verification
The hardest states to reach from the ports are the ones where automatic kill overlaps with slot phase. Examples are a stuck run that ends on a 4:1:1 discard slot, or one that ends while only one component has been refilled. Uniform random bytes almost never produce two stuck codes in a row. The random stimulus therefore draws 0x00 or 0xFF about a quarter of the time, and it changes format, order and line starts while that is happening. Directed sequences cover the clamp edges and single and double stuck codes.

// File: rtl/ycf_pkg.sv
package ycf_pkg;
    localparam int PIX_W  = 8;
    localparam int SLOT_W = 2;

    typedef logic [PIX_W-1:0] pix_t;

    localparam pix_t Y_MIN = pix_t'(16);
    localparam pix_t Y_MAX = pix_t'(235);
    localparam pix_t C_MIN = pix_t'(16);
    localparam pix_t C_MAX = pix_t'(240);
    localparam pix_t C_MID = pix_t'(1 << (PIX_W - 1));
    localparam int   C_SPAN = 112;
    localparam pix_t CODE_LO = '0;
    localparam pix_t CODE_HI = '1;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_A = 2'd0,
        SLOT_B = 2'd1,
        SLOT_C = 2'd2,
        SLOT_D = 2'd3
    } slot_e;

    typedef struct packed {
        pix_t cb;
        pix_t cr;
    } chroma_pair_t;

    function automatic pix_t clamp_luma(input pix_t raw);
        if (raw < Y_MIN) return Y_MIN;
        if (raw > Y_MAX) return Y_MAX;
        return raw;
    endfunction

    function automatic pix_t clamp_chroma(input pix_t raw, input logic twos);
        int sv;
        if (!twos) begin
            if (raw < C_MIN) return C_MIN;
            if (raw > C_MAX) return C_MAX;
            return raw;
        end
        sv = int'($signed(raw));
        if (sv < -C_SPAN) return C_MIN;
        if (sv > C_SPAN)  return C_MAX;
        return pix_t'(sv + int'(C_MID));
    endfunction

    function automatic logic is_stuck(input pix_t raw);
        return (raw == CODE_LO) || (raw == CODE_HI);
    endfunction
endpackage

// File: rtl/ycf_slot_ctr.sv
module ycf_slot_ctr
    import ycf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  line_start,
    output slot_e slot_now,
    output logic  seen_q
);
    logic [SLOT_W-1:0] cnt_q;

    assign slot_now = line_start ? SLOT_A : slot_e'(cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            cnt_q  <= SLOT_W'(slot_now) + SLOT_W'(1);
            seen_q <= seen_q | line_start;
        end
    end
endmodule

// File: rtl/ycf_kill_det.sv
module ycf_kill_det
    import ycf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pix_t chroma_in,
    input  logic kill_force,
    output logic kill_now
);
    logic stuck_now;
    logic stuck_q;

    assign stuck_now = is_stuck(chroma_in);
    assign kill_now  = kill_force | (stuck_now & stuck_q);

    always_ff @(posedge clk) begin
        if (rst) stuck_q <= 1'b0;
        else     stuck_q <= stuck_now;
    end
endmodule

// File: rtl/ycf_chroma_route.sv
module ycf_chroma_route
    import ycf_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  slot_e        slot_now,
    input  logic         fmt_411,
    input  logic         first_is_cb,
    input  pix_t         chroma_val,
    input  logic         kill_now,
    output chroma_pair_t pair_q
);
    logic data_slot;
    logic second_slot;
    logic [1:0] take;   // [0] = Cb, [1] = Cr
    pix_t comp_q [2];

    always_comb begin
        if (fmt_411) begin
            data_slot   = (slot_now == SLOT_A) || (slot_now == SLOT_B);
            second_slot = (slot_now == SLOT_B);
        end else begin
            data_slot   = 1'b1;
            second_slot = (slot_now == SLOT_B) || (slot_now == SLOT_D);
        end
        take[0] = data_slot & (first_is_cb ^ second_slot);
        take[1] = data_slot & ~(first_is_cb ^ second_slot);
    end

    for (genvar g = 0; g < 2; g++) begin : g_comp
        always_ff @(posedge clk) begin
            if (rst || kill_now) comp_q[g] <= C_MID;
            else if (take[g])    comp_q[g] <= chroma_val;
        end
    end

    assign pair_q.cb = comp_q[0];
    assign pair_q.cr = comp_q[1];
endmodule

// File: rtl/chroma_luma_formatter.sv
module chroma_luma_formatter
    import ycf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] luma_in,
    input  logic [7:0] chroma_in,
    input  logic       order_pin,
    input  logic       order_invert,
    input  logic       fmt_411,
    input  logic       chroma_twos,
    input  logic       line_start,
    input  logic       kill_force,
    output logic [7:0] out_y,
    output logic [7:0] out_cb,
    output logic [7:0] out_cr,
    output logic       out_valid
);
    slot_e        slot_now;
    logic         seen_q;
    logic         kill_now;
    chroma_pair_t pair_q;
    pix_t         y_q;
    logic         valid_q;

    ycf_slot_ctr u_slot (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .slot_now   (slot_now),
        .seen_q     (seen_q)
    );

    ycf_kill_det u_kill (
        .clk        (clk),
        .rst        (rst),
        .chroma_in  (chroma_in),
        .kill_force (kill_force),
        .kill_now   (kill_now)
    );

    ycf_chroma_route u_route (
        .clk         (clk),
        .rst         (rst),
        .slot_now    (slot_now),
        .fmt_411     (fmt_411),
        .first_is_cb (order_pin ^ order_invert),
        .chroma_val  (clamp_chroma(chroma_in, chroma_twos)),
        .kill_now    (kill_now),
        .pair_q      (pair_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q     <= Y_MIN;
            valid_q <= 1'b0;
        end else begin
            y_q     <= clamp_luma(luma_in);
            valid_q <= seen_q | line_start;
        end
    end

    assign out_y     = y_q;
    assign out_cb    = pair_q.cb;
    assign out_cr    = pair_q.cr;
    assign out_valid = valid_q;
endmodule

// File: rtl/ycf_chk.sv
module ycf_chk
    import ycf_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [7:0] luma_in,
    input logic [7:0] chroma_in,
    input logic       line_start,
    input logic       kill_force,
    input logic [7:0] out_y,
    input logic [7:0] out_cb,
    input logic [7:0] out_cr,
    input logic       out_valid
);
    logic prev_stuck;

    always_ff @(posedge clk) begin
        if (rst) prev_stuck <= 1'b0;
        else     prev_stuck <= is_stuck(chroma_in);
    end

    // R1
    luma_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_y >= Y_MIN && out_y <= Y_MAX);

    // R1
    luma_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (luma_in >= Y_MIN && luma_in <= Y_MAX) |=> out_y == $past(luma_in));

    // R2
    chroma_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_cb >= C_MIN && out_cb <= C_MAX && out_cr >= C_MIN && out_cr <= C_MAX);

    // R7
    auto_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (is_stuck(chroma_in) && prev_stuck) |=> (out_cb == C_MID && out_cr == C_MID));

    // R8
    force_kill_chk: assert property (@(posedge clk) disable iff (rst)
        kill_force |=> (out_cb == C_MID && out_cr == C_MID));

    // R9
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |=> out_valid);

    // R9
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);
endmodule

bind chroma_luma_formatter ycf_chk u_ycf_chk (
    .clk        (clk),
    .rst        (rst),
    .luma_in    (luma_in),
    .chroma_in  (chroma_in),
    .line_start (line_start),
    .kill_force (kill_force),
    .out_y      (out_y),
    .out_cb     (out_cb),
    .out_cr     (out_cr),
    .out_valid  (out_valid)
);

// File: tb/tb_chroma_luma_formatter.sv
`timescale 1ns/1ps
module tb_chroma_luma_formatter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] luma_in = 8'd0, chroma_in = 8'd0;
    logic       order_pin = 1'b1, order_invert = 1'b0, fmt_411 = 1'b0;
    logic       chroma_twos = 1'b0, line_start = 1'b0, kill_force = 1'b0;
    logic [7:0] out_y, out_cb, out_cr;
    logic       out_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int n_cyc   = 0;

    // model state
    logic [1:0] m_cnt = 2'd0;
    logic       m_pst = 1'b0, m_seen = 1'b0;
    logic [7:0] e_y = 8'd16, e_cb = 8'd128, e_cr = 8'd128;
    logic       e_v = 1'b0;

    always #2 clk = ~clk;

    chroma_luma_formatter dut (
        .clk(clk), .rst(rst), .luma_in(luma_in), .chroma_in(chroma_in),
        .order_pin(order_pin), .order_invert(order_invert), .fmt_411(fmt_411),
        .chroma_twos(chroma_twos), .line_start(line_start), .kill_force(kill_force),
        .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr), .out_valid(out_valid)
    );

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired: got running, expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] b_luma(input logic [7:0] v);
        return (v < 8'd16) ? 8'd16 : (v > 8'd235) ? 8'd235 : v;
    endfunction

    function automatic logic [7:0] b_chroma(input logic [7:0] v, input logic tw);
        int s;
        if (!tw) return (v < 8'd16) ? 8'd16 : (v > 8'd240) ? 8'd240 : v;
        s = (v > 8'd127) ? int'(v) - 256 : int'(v);
        if (s < -112) return 8'd16;
        if (s > 112)  return 8'd240;
        return 8'(s + 128);
    endfunction

    function automatic logic b_stuck(input logic [7:0] v);
        return v == 8'h00 || v == 8'hFF;
    endfunction

    task automatic model_step();
        logic [1:0] slot;
        logic kill, dslot, sec, fcb;
        slot  = line_start ? 2'd0 : m_cnt;
        m_cnt = slot + 2'd1;
        kill  = kill_force | (b_stuck(chroma_in) & m_pst);
        m_pst = b_stuck(chroma_in);
        e_v   = m_seen | line_start;
        m_seen = m_seen | line_start;
        e_y   = b_luma(luma_in);
        fcb   = order_pin ^ order_invert;
        dslot = fmt_411 ? (slot < 2'd2) : 1'b1;
        sec   = fmt_411 ? (slot == 2'd1) : slot[0];
        if (kill) begin
            e_cb = 8'd128; e_cr = 8'd128;
        end else if (dslot) begin
            if (fcb ^ sec) e_cb = b_chroma(chroma_in, chroma_twos);
            else           e_cr = b_chroma(chroma_in, chroma_twos);
        end
    endtask

    task automatic compare(input string tag);
        n_tests++;
        if (out_y !== e_y || out_cb !== e_cb || out_cr !== e_cr || out_valid !== e_v) begin
            n_fail++;
            $display("FAIL %s: got y=%0d cb=%0d cr=%0d v=%0b, expected y=%0d cb=%0d cr=%0d v=%0b",
                     tag, out_y, out_cb, out_cr, out_valid, e_y, e_cb, e_cr, e_v);
        end
    endtask

    task automatic cyc(input logic [7:0] y, input logic [7:0] c, input logic ls,
                       input logic kf, input string tag);
        luma_in = y; chroma_in = c; line_start = ls; kill_force = kf;
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        // R10 reset values
        n_tests++;
        if (out_y !== 8'd16 || out_cb !== 8'd128 || out_cr !== 8'd128 || out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: got y=%0d cb=%0d cr=%0d v=%0b, expected 16 128 128 0",
                     out_y, out_cb, out_cr, out_valid);
        end
        rst = 1'b0;

        // R9 no line start yet: valid stays low
        cyc(8'd100, 8'd50, 1'b0, 1'b0, "R9 before line start");
        cyc(8'd100, 8'd60, 1'b0, 1'b0, "R9 before line start");
        // R4 R5: order pin high, no invert -> slot 0 is Cb
        cyc(8'd0,   8'd90,  1'b1, 1'b0, "R4 R1 R9 slot0 Cb");
        cyc(8'd15,  8'd170, 1'b0, 1'b0, "R5 R1 slot1 Cr");
        cyc(8'd236, 8'd100, 1'b0, 1'b0, "R5 R1 slot2 Cb");
        cyc(8'd255, 8'd5,   1'b0, 1'b0, "R2 R1 low clamp");
        cyc(8'd235, 8'd250, 1'b0, 1'b0, "R2 R1 high clamp");
        // R4 inversion flips the pin
        order_invert = 1'b1;
        cyc(8'd16,  8'd77, 1'b1, 1'b0, "R4 inverted slot0 Cr");
        cyc(8'd50,  8'd88, 1'b0, 1'b0, "R4 inverted slot1 Cb");
        order_pin = 1'b0; order_invert = 1'b0;
        cyc(8'd60,  8'd99, 1'b1, 1'b0, "R4 pin low slot0 Cr");
        // R3 two's complement
        chroma_twos = 1'b1;
        cyc(8'd60, 8'h80, 1'b1, 1'b0, "R3 -128");
        cyc(8'd60, 8'h90, 1'b0, 1'b0, "R3 -112");
        cyc(8'd60, 8'h70, 1'b0, 1'b0, "R3 +112");
        cyc(8'd60, 8'h7F, 1'b0, 1'b0, "R3 +127");
        cyc(8'd60, 8'h00, 1'b0, 1'b0, "R3 R7 single zero");
        cyc(8'd60, 8'h20, 1'b0, 1'b0, "R3 +32");
        chroma_twos = 1'b0;
        // R7 automatic kill
        cyc(8'd80, 8'h00, 1'b0, 1'b0, "R7 first stuck no kill");
        cyc(8'd80, 8'hFF, 1'b0, 1'b0, "R7 second stuck kill");
        cyc(8'd80, 8'hFF, 1'b0, 1'b0, "R7 still killed");
        cyc(8'd80, 8'h40, 1'b0, 1'b0, "R7 kill ends");
        cyc(8'd80, 8'h50, 1'b0, 1'b0, "R7 refill other");
        // R8 manual kill
        cyc(8'd80, 8'h66, 1'b0, 1'b1, "R8 forced");
        cyc(8'd80, 8'h67, 1'b0, 1'b0, "R8 release");
        // R6 4:1:1 discard slots
        fmt_411 = 1'b1; order_pin = 1'b1;
        cyc(8'd90, 8'd30,  1'b1, 1'b0, "R6 slot0");
        cyc(8'd90, 8'd40,  1'b0, 1'b0, "R6 slot1");
        cyc(8'd90, 8'd200, 1'b0, 1'b0, "R6 slot2 ignored");
        cyc(8'd90, 8'd210, 1'b0, 1'b0, "R6 slot3 ignored");
        cyc(8'd90, 8'd50,  1'b0, 1'b0, "R6 wrap slot0");
        cyc(8'd90, 8'd60,  1'b0, 1'b0, "R6 wrap slot1");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] c;
            if (i % 40 == 0) begin
                order_pin    = 1'($urandom);
                order_invert = 1'($urandom);
                fmt_411      = 1'($urandom);
                chroma_twos  = 1'($urandom);
            end
            if ($urandom_range(3) == 0) c = $urandom_range(1) ? 8'hFF : 8'h00;
            else                        c = 8'($urandom);
            cyc(8'($urandom), c, $urandom_range(49) == 0, $urandom_range(29) == 0,
                "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        // R10 reset mid-stream
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        m_cnt = 2'd0; m_pst = 1'b0; m_seen = 1'b0;
        e_y = 8'd16; e_cb = 8'd128; e_cr = 8'd128; e_v = 1'b0;
        compare("R10 reset mid-stream");
        rst = 1'b0;
        cyc(8'd120, 8'd140, 1'b0, 1'b0, "R9 R10 after reset");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule